// File: doc/BRIEF.md
# Two-Word Command Link with Triggered Reply

This block is the bottom layer of a host-to-logic word link. Starting from idle, it takes exactly two words from an incoming valid/ready word stream. The first word is the command and the second is the argument. It then signals the layer above with a one-cycle strobe and keeps both words on stable outputs.

After the pair arrives, the block goes quiet. It sends nothing until the layer above gives a trigger. A start trigger carries a reply length. The block then streams that many reply words to the host on a valid/ready output, one per handshake. For each word it puts out the index it needs, and the layer above answers with the word on a data input. A skip trigger, or a start trigger with length zero, sends the block straight back to idle with no reply.

A two-bit state code can drive diagnostic lamps, so a link that stops in one state can be seen. The block does not decode commands or produce reply data.

Top module: `word_pair_link`

## Requirements
- R1: After a synchronous reset, state_code is 0 (idle), in_ready is 1, out_valid is 0 and pair_strobe is 0.
- R2: In idle, the first accepted input word is stored as cmd_word and state_code becomes 1. The next accepted word is stored as arg_word and state_code becomes 2 (hold). in_ready is 0 whenever state_code is 2 or 3.
- R3: pair_strobe is 1 for exactly one cycle, the cycle right after the second word is accepted. In that cycle cmd_word and arg_word carry the received pair.
- R4: In hold, out_valid stays 0 for as long as no trigger arrives.
- R5: In hold, reply_go with reply_len=N>0 moves the block to state_code 3 (send). It then delivers exactly N words. While word k is offered, word_idx equals k and out_data equals reply_word. word_idx and out_valid do not change while out_ready is 0.
- R6: On the cycle after word N-1 is accepted, state_code is 0 and out_valid is 0.
- R7: In hold, reply_skip returns the block to idle with no word sent, and it wins over a reply_go given in the same cycle.
- R8: In hold, reply_go with reply_len=0 returns the block to idle with no word sent.
- R9: reply_go and reply_skip have no effect when state_code is 0 or 1.
- R10: A reset between the first and second word discards the first word. The next two accepted words form the pair.
- R11: cmd_word and arg_word do not change while state_code is 2 or 3, even when in_valid is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host word available |
| in_ready | output | 1 | Block accepts a host word |
| in_data | input | WORD_W | Host word |
| pair_strobe | output | 1 | One-cycle pulse when a pair is complete |
| cmd_word | output | WORD_W | First word of the pair |
| arg_word | output | WORD_W | Second word of the pair |
| reply_go | input | 1 | Start the reply (used in hold only) |
| reply_skip | input | 1 | Return to idle with no reply (used in hold only) |
| reply_len | input | CNT_W | Number of reply words, sampled with reply_go |
| word_idx | output | CNT_W | Index of the reply word now requested |
| reply_word | input | WORD_W | Reply word for word_idx, from the layer above |
| out_valid | output | 1 | Reply word offered to the host |
| out_ready | input | 1 | Host takes the reply word |
| out_data | output | WORD_W | Reply word to the host |
| state_code | output | 2 | 0 idle, 1 second word due, 2 hold, 3 send |

## Verification
Every result appears one clock edge after the handshake or trigger that causes it. Accepting the second word makes pair_strobe and state_code 2 visible after the next edge. A trigger shows up as state_code 3 or 0 one edge later. An accepted last reply word shows up as idle one edge later. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands exactly one register stage after its cause. The reply sweep covers lengths 0 to 5 under three host ready patterns.

// File: rtl/wpl_pkg.sv
package wpl_pkg;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_GET2 = 2'd1,
        LS_HOLD = 2'd2,
        LS_SEND = 2'd3
    } link_state_e;

    typedef struct packed {
        logic go;
        logic skip;
        logic len_zero;
    } trig_s;

    function automatic logic accepts_input(link_state_e s);
        return (s == LS_IDLE) || (s == LS_GET2);
    endfunction

endpackage

// File: rtl/wpl_ctrl.sv
module wpl_ctrl
    import wpl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_fire,
    input  trig_s       trig,
    input  logic        out_fire,
    input  logic        last_word,
    output link_state_e state,
    output logic        start_tx
);
    link_state_e nxt;

    always_comb begin
        nxt      = state;
        start_tx = 1'b0;
        unique case (state)
            LS_IDLE: if (in_fire) nxt = LS_GET2;
            LS_GET2: if (in_fire) nxt = LS_HOLD;
            LS_HOLD: begin
                if (trig.skip) begin
                    nxt = LS_IDLE;
                end else if (trig.go) begin
                    if (trig.len_zero) begin
                        nxt = LS_IDLE;
                    end else begin
                        nxt      = LS_SEND;
                        start_tx = 1'b1;
                    end
                end
            end
            LS_SEND: if (out_fire && last_word) nxt = LS_IDLE;
            default: nxt = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LS_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/wpl_rx.sv
module wpl_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         cap_first,
    input  logic         cap_second,
    output logic [W-1:0] first_q,
    output logic [W-1:0] second_q,
    output logic         done_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            first_q    <= '0;
            second_q   <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= cap_second;
            if (cap_first)  first_q  <= din;
            if (cap_second) second_q <= din;
        end
    end
endmodule

// File: rtl/wpl_tx.sv
module wpl_tx #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    input  logic          advance,
    output logic [CW-1:0] idx,
    output logic          last
);
    logic [CW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            len_q <= '0;
        end else if (load) begin
            idx   <= '0;
            len_q <= len;
        end else if (advance) begin
            idx <= idx + CW'(1);
        end
    end

    assign last = (idx == len_q - CW'(1));
endmodule

// File: rtl/word_pair_link.sv
module word_pair_link
    import wpl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              pair_strobe,
    output logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] arg_word,
    input  logic              reply_go,
    input  logic              reply_skip,
    input  logic [CNT_W-1:0]  reply_len,
    output logic [CNT_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] reply_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [1:0]        state_code
);
    link_state_e state;
    trig_s       trig;
    logic        in_fire, out_fire, last_word, start_tx;

    assign in_ready   = accepts_input(state);
    assign in_fire    = in_valid && in_ready;
    assign out_valid  = (state == LS_SEND);
    assign out_fire   = out_valid && out_ready;
    assign out_data   = reply_word;
    assign state_code = state;

    assign trig.go       = reply_go;
    assign trig.skip     = reply_skip;
    assign trig.len_zero = (reply_len == '0);

    wpl_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_fire   (in_fire),
        .trig      (trig),
        .out_fire  (out_fire),
        .last_word (last_word),
        .state     (state),
        .start_tx  (start_tx)
    );

    wpl_rx #(.W(WORD_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .din        (in_data),
        .cap_first  (in_fire && state == LS_IDLE),
        .cap_second (in_fire && state == LS_GET2),
        .first_q    (cmd_word),
        .second_q   (arg_word),
        .done_pulse (pair_strobe)
    );

    wpl_tx #(.CW(CNT_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (start_tx),
        .len     (reply_len),
        .advance (out_fire),
        .idx     (word_idx),
        .last    (last_word)
    );
endmodule

// File: rtl/wpl_chk.sv
module wpl_chk #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              pair_strobe,
    input logic [WORD_W-1:0] cmd_word,
    input logic [WORD_W-1:0] arg_word,
    input logic [CNT_W-1:0]  word_idx,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        state_code
);
    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code[1]) |-> !in_ready);

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        pair_strobe |=> !pair_strobe);

    // R3
    strobe_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pair_strobe |-> (state_code == 2'd2));

    // R4
    no_early_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code != 2'd3) |-> !out_valid);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(word_idx)));

    // R11
    pair_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code[1] && $past(state_code[1])) |-> ($stable(cmd_word) && $stable(arg_word)));
endmodule

bind word_pair_link wpl_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_wpl_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .pair_strobe (pair_strobe),
    .cmd_word    (cmd_word),
    .arg_word    (arg_word),
    .word_idx    (word_idx),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .state_code  (state_code)
);

// File: tb/test_word_pair_link.sv
module test_word_pair_link;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic          pair_strobe;
    logic [W-1:0]  cmd_word, arg_word;
    logic          reply_go = 1'b0, reply_skip = 1'b0;
    logic [CW-1:0] reply_len = '0;
    logic [CW-1:0] word_idx;
    logic [W-1:0]  reply_word;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [W-1:0]  out_data;
    logic [1:0]    state_code;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    word_pair_link #(.WORD_W(W), .CNT_W(CW)) i_word_pair_link (.*);

    function automatic logic [W-1:0] exp_word(logic [CW-1:0] k, logic [W-1:0] c);
        return (c ^ (W'(k) * 16'h0123)) + 16'h005A;
    endfunction

    assign reply_word = exp_word(word_idx, cmd_word);

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(logic [W-1:0] w);
        check(in_ready == 1'b1, "R2 in_ready", in_ready, 1);
        in_valid = 1'b1;
        in_data  = w;
        tick();
        in_valid = 1'b0;
    endtask

    task automatic get_pair(logic [W-1:0] c, logic [W-1:0] a);
        push(c);
        check(state_code == 2'd1, "R2 state after first", state_code, 1);
        push(a);
        check(state_code == 2'd2, "R2 state hold", state_code, 2);
        check(pair_strobe == 1'b1, "R3 strobe high", pair_strobe, 1);
        check(cmd_word == c, "R3 cmd word", cmd_word, c);
        check(arg_word == a, "R3 arg word", arg_word, a);
        tick();
        check(pair_strobe == 1'b0, "R3 strobe single", pair_strobe, 0);
    endtask

    task automatic trigger(bit go, bit skip, int n);
        reply_go   = go;
        reply_skip = skip;
        reply_len  = CW'(n);
        tick();
        reply_go   = 1'b0;
        reply_skip = 1'b0;
    endtask

    // collect n words with ready pattern p: 0 always, 1 alternate, 2 one in three
    task automatic collect(int n, int p, logic [W-1:0] c);
        int got = 0;
        int cyc = 0;
        while (state_code == 2'd3 && cyc < 200) begin
            bit rdy = (p == 0) || (p == 1 && cyc % 2 == 1) || (p == 2 && cyc % 3 == 2);
            check(out_valid == 1'b1, "R5 out_valid in send", out_valid, 1);
            check(word_idx == CW'(got), "R5 word index", word_idx, got);
            check(out_data == exp_word(CW'(got), c), "R5 out_data", out_data, exp_word(CW'(got), c));
            out_ready = rdy;
            tick();
            out_ready = 1'b0;
            if (rdy) got++;
            cyc++;
        end
        check(got == n, "R5 word count", got, n);
        check(state_code == 2'd0, "R6 idle after reply", state_code, 0);
        check(out_valid == 1'b0, "R6 out_valid low", out_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        @(negedge clk);
        tick();
        rst = 1'b0;
        // R1 reset state
        check(state_code == 2'd0, "R1 state", state_code, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(pair_strobe == 1'b0, "R1 strobe", pair_strobe, 0);

        // R5 R6 R8 sweep of lengths and ready patterns
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n < 6; n++) begin
                logic [W-1:0] c = W'(16'h1000 + p * 16'h0100 + n);
                logic [W-1:0] a = ~c;
                get_pair(c, a);
                // R4 quiet wait with in_valid held (R11)
                in_valid = 1'b1;
                in_data  = 16'hDEAD;
                for (int k = 0; k < 3; k++) begin
                    tick();
                    check(out_valid == 1'b0, "R4 no reply before trigger", out_valid, 0);
                    check(state_code == 2'd2, "R4 stays in hold", state_code, 2);
                end
                in_valid = 1'b0;
                check(cmd_word == c && arg_word == a, "R11 pair held", cmd_word, c);
                trigger(1'b1, 1'b0, n);
                if (n == 0) begin
                    check(state_code == 2'd0, "R8 zero length idle", state_code, 0);
                    check(out_valid == 1'b0, "R8 no word", out_valid, 0);
                end else begin
                    check(state_code == 2'd3, "R5 send state", state_code, 3);
                    collect(n, p, c);
                end
            end
        end

        // R7 skip wins over go
        get_pair(16'hA5A5, 16'h0F0F);
        trigger(1'b1, 1'b1, 4);
        check(state_code == 2'd0, "R7 skip to idle", state_code, 0);
        check(out_valid == 1'b0, "R7 no word", out_valid, 0);
        get_pair(16'h1357, 16'h2468);
        trigger(1'b0, 1'b1, 0);
        check(state_code == 2'd0, "R7 plain skip", state_code, 0);

        // R9 triggers ignored in idle and after first word
        trigger(1'b1, 1'b0, 3);
        check(state_code == 2'd0, "R9 idle ignores go", state_code, 0);
        check(out_valid == 1'b0, "R9 idle no word", out_valid, 0);
        push(16'h7777);
        trigger(1'b1, 1'b1, 3);
        check(state_code == 2'd1, "R9 get2 ignores trig", state_code, 1);
        push(16'h8888);
        check(cmd_word == 16'h7777 && arg_word == 16'h8888, "R9 pair intact", arg_word, 16'h8888);
        trigger(1'b1, 1'b0, 2);
        collect(2, 0, 16'h7777);

        // R10 reset drops half pair
        push(16'hBEEF);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check(state_code == 2'd0, "R10 idle after reset", state_code, 0);
        get_pair(16'h4242, 16'h9999);
        check(cmd_word == 16'h4242, "R10 new command", cmd_word, 16'h4242);

        finish_up();
    end
endmodule